// File: doc/BRIEF.md
# Host-to-Engine Doorbell Mailbox

This block sits between a host that talks over a simple 32-bit register bus and a responder engine that carries out commands. The host stages up to five argument words in a write buffer, then writes a single command word. That write latches the command, marks the mailbox busy and rings a one-cycle doorbell toward the engine. The engine reads the latched command and the staged words, may deposit up to four result words into a read buffer, and then signals completion with an error flag, an error code and an initiator tag.

The host learns of completion in one of two ways, and it picks the way in the same command word that starts the job. With the interrupt-on-completion bit set, completion raises a single-cycle interrupt pulse that needs no acknowledgement. With it clear, the host polls the busy bit in the status register until it falls and then inspects the error bit and the code. A command written while a job is still running is dropped, and a sticky overrun bit records that this happened.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset the status register reads zero, the doorbell and the interrupt are low, and the write buffer and read buffer hold zero.
- R2: A host write to the command register (address 0x00) while idle latches the whole word on the command output, raises busy (status bit 0) in the next cycle, pulses the doorbell high for exactly that one cycle, copies command bits [15:12] into status bits [7:4] and clears the error bit and the overrun bit.
- R3: Completion sampled while busy clears busy at that same edge and loads the error flag into status bit 1, the initiator tag into status bits [15:8] and the error code into status bits [23:16]; these fields hold their values until the next completion.
- R4: When command bit 8 was set in the accepted command, the interrupt output is high for exactly the one cycle after completion; when it was clear, completion produces no interrupt.
- R5: A command write arriving while busy is ignored (command output unchanged, no doorbell) and sets the overrun flag in status bit 2, which stays set until the next accepted command.
- R6: Host writes to address 0x80 + 4k for k = 0..4 load word k of the write buffer (word k at bits [32k+31:32k] of the flat output); writes to 0x94, 0x98 and 0x9C change no write-buffer word.
- R7: The responder loads read-buffer word k (k = 0..3); a host read at 0x90 + 4k with byte mode low returns that word, and with byte mode high returns byte (address bits [1:0]) of that word in bits [7:0] with the upper bits zero.
- R8: A completion signalled while idle changes no status field and raises no interrupt.
- R9: Reads of the status register (0x04) return the status word; reads of any address outside the status register and the read buffer return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe for one cycle |
| regAddr | input | 8 | Host byte address for reads and writes |
| regWdata | input | 32 | Host write data |
| regByte | input | 1 | Read-buffer access returns one byte when high |
| regRdata | output | 32 | Host read data, combinational from regAddr |
| reqStart | output | 1 | Doorbell pulse toward the responder |
| reqCmd | output | 32 | Latched command word |
| wrBufFlat | output | 160 | Write-buffer words, word k in bits [32k+31:32k] |
| rspDone | input | 1 | Responder completion strobe |
| rspError | input | 1 | Error flag sampled with completion |
| rspCode | input | 8 | Error code sampled with completion |
| rspInitiator | input | 8 | Initiator tag sampled with completion |
| rspRdWe | input | 1 | Responder write into the read buffer |
| rspRdIdx | input | 2 | Read-buffer word index for rspRdWe |
| rspRdData | input | 32 | Read-buffer word data |
| irqPulse | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach from the ports is a second command landing on a busy mailbox, because only a host that ignores busy produces it and the outcome must be seen as an absence of doorbell and an unchanged command output. The stimulus inserts such a colliding write at random in about a third of the jobs, then follows the next accepted command to confirm the overrun bit is cleared again. Completions arriving while idle are injected between jobs with fresh random values, so that any leak into the status fields or the interrupt shows up on the next status read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int CMD_ADDR = 'h00;
  localparam int STATUS_ADDR = 'h04;
  localparam int WBUF_BASE = 'h80;
  localparam int RBUF_BASE = 'h90;
  localparam int IOC_BIT = 8;

  typedef struct packed {
    logic cmdAccept;
    logic cmdReject;
    logic doneAccept;
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              iocIn,
  input  logic              rspDone,
  output mboxStrobes_t      strb,
  output logic              busy,
  output logic              overrun,
  output logic              reqStart,
  output logic              irqPulse
);
  logic cmdHit;
  logic iocQ;

  assign cmdHit          = regWrEn && (regAddr == ADDR_W'(CMD_ADDR));
  assign strb.cmdAccept  = cmdHit && !busy;
  assign strb.cmdReject  = cmdHit && busy;
  assign strb.doneAccept = rspDone && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      overrun  <= 1'b0;
      reqStart <= 1'b0;
      irqPulse <= 1'b0;
      iocQ     <= 1'b0;
    end else begin
      reqStart <= strb.cmdAccept;
      irqPulse <= strb.doneAccept && iocQ;
      if (strb.cmdAccept) begin
        busy    <= 1'b1;
        iocQ    <= iocIn;
        overrun <= 1'b0;
      end else if (strb.doneAccept) begin
        busy <= 1'b0;
      end
      if (strb.cmdReject) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int WBUF_WORDS = 5,
  parameter int RBUF_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mboxStrobes_t                 strb,
  input  logic                         busy,
  input  logic                         overrun,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [WORD_W-1:0]            regWdata,
  input  logic                         regByte,
  output logic [WORD_W-1:0]            regRdata,
  output logic [WORD_W-1:0]            statusWord,
  output logic [WORD_W-1:0]            reqCmd,
  output logic [WBUF_WORDS*WORD_W-1:0] wrBufFlat,
  input  logic                         rspError,
  input  logic [7:0]                   rspCode,
  input  logic [7:0]                   rspInitiator,
  input  logic                         rspRdWe,
  input  logic [$clog2(RBUF_WORDS)-1:0] rspRdIdx,
  input  logic [WORD_W-1:0]            rspRdData
);
  localparam int RIDX_W = $clog2(RBUF_WORDS);
  localparam int RBUF_END = RBUF_BASE + 4 * RBUF_WORDS;

  logic              errQ;
  logic [7:0]        codeQ;
  logic [7:0]        initQ;
  logic [WORD_W-1:0] rbufQ [RBUF_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqCmd <= '0;
      errQ   <= 1'b0;
      codeQ  <= '0;
      initQ  <= '0;
    end else if (strb.cmdAccept) begin
      reqCmd <= regWdata;
      errQ   <= 1'b0;
    end else if (strb.doneAccept) begin
      errQ  <= rspError;
      codeQ <= rspCode;
      initQ <= rspInitiator;
    end
  end

  for (genvar k = 0; k < WBUF_WORDS; k++) begin : gWbuf
    always_ff @(posedge clk) begin
      if (!rstN)
        wrBufFlat[k*WORD_W +: WORD_W] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(WBUF_BASE + 4 * k))
        wrBufFlat[k*WORD_W +: WORD_W] <= regWdata;
    end
  end

  for (genvar k = 0; k < RBUF_WORDS; k++) begin : gRbuf
    always_ff @(posedge clk) begin
      if (!rstN)
        rbufQ[k] <= '0;
      else if (rspRdWe && rspRdIdx == RIDX_W'(k))
        rbufQ[k] <= rspRdData;
    end
  end

  assign statusWord = {8'h00, codeQ, initQ, reqCmd[15:12], 1'b0, overrun, errQ, busy};

  logic [ADDR_W-1:0] rOff;
  logic [RIDX_W-1:0] rIdx;
  logic              rHit;
  logic [WORD_W-1:0] rWord;

  assign rOff  = regAddr - ADDR_W'(RBUF_BASE);
  assign rIdx  = rOff[RIDX_W+1:2];
  assign rHit  = (regAddr >= ADDR_W'(RBUF_BASE)) && (regAddr < ADDR_W'(RBUF_END));
  assign rWord = rbufQ[rIdx];

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(STATUS_ADDR))
      regRdata = statusWord;
    else if (rHit && regByte)
      regRdata = {24'h0, rWord[{regAddr[1:0], 3'b000} +: 8]};
    else if (rHit)
      regRdata = rWord;
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import mbox_pkg::*;
#(
  parameter int WBUF_WORDS = 5,
  parameter int RBUF_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [WORD_W-1:0]             regWdata,
  input  logic                          regByte,
  output logic [WORD_W-1:0]             regRdata,
  output logic                          reqStart,
  output logic [WORD_W-1:0]             reqCmd,
  output logic [WBUF_WORDS*WORD_W-1:0]  wrBufFlat,
  input  logic                          rspDone,
  input  logic                          rspError,
  input  logic [7:0]                    rspCode,
  input  logic [7:0]                    rspInitiator,
  input  logic                          rspRdWe,
  input  logic [$clog2(RBUF_WORDS)-1:0] rspRdIdx,
  input  logic [WORD_W-1:0]             rspRdData,
  output logic                          irqPulse
);
  mboxStrobes_t      strb;
  logic              busy;
  logic              overrun;
  logic [WORD_W-1:0] statusWord;

  mbox_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .iocIn(regWdata[IOC_BIT]), .rspDone(rspDone), .strb(strb),
    .busy(busy), .overrun(overrun), .reqStart(reqStart), .irqPulse(irqPulse)
  );

  mbox_dpath #(.WBUF_WORDS(WBUF_WORDS), .RBUF_WORDS(RBUF_WORDS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .overrun(overrun),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regByte(regByte),
    .regRdata(regRdata), .statusWord(statusWord), .reqCmd(reqCmd),
    .wrBufFlat(wrBufFlat), .rspError(rspError), .rspCode(rspCode),
    .rspInitiator(rspInitiator), .rspRdWe(rspRdWe), .rspRdIdx(rspRdIdx),
    .rspRdData(rspRdData)
  );
endmodule

// File: rtl/doorbell_mailbox_chk.sv
module doorbell_mailbox_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              rspDone,
  input logic              busy,
  input logic              reqStart,
  input logic [WORD_W-1:0] reqCmd,
  input logic [WORD_W-1:0] statusWord,
  input logic              irqPulse
);
  logic cmdWr;
  assign cmdWr = regWrEn && (regAddr == ADDR_W'(CMD_ADDR));

  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy) |=> (busy && reqStart));

  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqStart |=> !reqStart);

  assert_done_clears_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rspDone) |=> !busy);

  assert_irq_follows_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(busy && rspDone));

  assert_reject_while_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy) |=> ($stable(reqCmd) && !reqStart && statusWord[2]));

  assert_idle_done_inert_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && !busy && !cmdWr) |=> (!irqPulse && !busy && $stable(statusWord)));
endmodule

bind doorbell_mailbox doorbell_mailbox_chk uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .rspDone(rspDone), .busy(busy), .reqStart(reqStart), .reqCmd(reqCmd),
  .statusWord(statusWord), .irqPulse(irqPulse)
);

// File: tb/tb_doorbell_mailbox.sv
module tb_doorbell_mailbox;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [7:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic         regByte = 1'b0;
  logic [31:0]  regRdata;
  logic         reqStart;
  logic [31:0]  reqCmd;
  logic [159:0] wrBufFlat;
  logic         rspDone = 1'b0;
  logic         rspError = 1'b0;
  logic [7:0]   rspCode = '0;
  logic [7:0]   rspInitiator = '0;
  logic         rspRdWe = 1'b0;
  logic [1:0]   rspRdIdx = '0;
  logic [31:0]  rspRdData = '0;
  logic         irqPulse;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  doorbell_mailbox dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regByte(regByte), .regRdata(regRdata),
    .reqStart(reqStart), .reqCmd(reqCmd), .wrBufFlat(wrBufFlat),
    .rspDone(rspDone), .rspError(rspError), .rspCode(rspCode),
    .rspInitiator(rspInitiator), .rspRdWe(rspRdWe), .rspRdIdx(rspRdIdx),
    .rspRdData(rspRdData), .irqPulse(irqPulse)
  );

  // model state
  logic [31:0] mWbuf [5];
  logic [31:0] mRbuf [4];
  logic [31:0] mCmd;
  logic        mErr, mOvr, mIoc;
  logic [7:0]  mCode, mInit;

  function automatic logic [31:0] expStatus(input logic b);
    return {8'h00, mCode, mInit, mCmd[15:12], 1'b0, mOvr, mErr, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, input logic byteMode, output logic [31:0] d);
    regAddr = a; regByte = byteMode;
    #1 d = regRdata;
    regByte = 1'b0;
  endtask

  task automatic rbufLoad(input logic [1:0] idx, input logic [31:0] d);
    rspRdIdx = idx; rspRdData = d; rspRdWe = 1'b1;
    @(negedge clk);
    rspRdWe = 1'b0;
  endtask

  task automatic complete(input logic e, input logic [7:0] c, input logic [7:0] t);
    rspError = e; rspCode = c; rspInitiator = t; rspDone = 1'b1;
    @(negedge clk);
    rspDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd2718));
    for (int k = 0; k < 5; k++) mWbuf[k] = '0;
    for (int k = 0; k < 4; k++) mRbuf[k] = '0;
    mCmd = '0; mErr = 0; mOvr = 0; mIoc = 0; mCode = '0; mInit = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    hostRead(8'h04, 1'b0, rd); chk("R1 status", rd, 32'h0);
    chk("R1 doorbell", {31'h0, reqStart}, 32'h0);
    chk("R1 irq", {31'h0, irqPulse}, 32'h0);
    chk("R1 wbuf", {31'h0, |wrBufFlat}, 32'h0);
    hostRead(8'h9C, 1'b0, rd); chk("R1 rbuf", rd, 32'h0);
    // R9 unmapped read
    hostRead(8'h00, 1'b0, rd); chk("R9 cmd reads zero", rd, 32'h0);

    // R8 done while idle right after reset
    complete(1'b1, 8'hAA, 8'h55);
    chk("R8 no irq", {31'h0, irqPulse}, 32'h0);
    hostRead(8'h04, 1'b0, rd); chk("R8 status kept", rd, expStatus(1'b0));

    for (int it = 0; it < 60; it++) begin
      logic [31:0] cw;
      logic [1:0] widx;
      // R6 write buffer plus stray writes past the end
      for (int k = 0; k < 5; k++) begin
        mWbuf[k] = $urandom;
        hostWrite(8'(8'h80 + 4 * k), mWbuf[k]);
      end
      hostWrite(8'(8'h94 + 4 * ($urandom % 3)), $urandom);
      for (int k = 0; k < 5; k++)
        chk("R6 wbuf word", wrBufFlat[k*32 +: 32], mWbuf[k]);

      // R2 accept
      cw = $urandom;
      cw[8] = (it < 2) ? it[0] : 1'($urandom % 2);
      hostWrite(8'h00, cw);
      mCmd = cw; mIoc = cw[8]; mErr = 0; mOvr = 0;
      chk("R2 doorbell", {31'h0, reqStart}, 32'h1);
      chk("R2 cmd latched", reqCmd, mCmd);
      hostRead(8'h04, 1'b0, rd); chk("R2 status busy", rd, expStatus(1'b1));
      @(negedge clk);
      chk("R2 doorbell one cycle", {31'h0, reqStart}, 32'h0);

      // R5 collision
      if (it == 0 || ($urandom % 3) == 0) begin
        hostWrite(8'h00, ~cw);
        mOvr = 1;
        chk("R5 no doorbell", {31'h0, reqStart}, 32'h0);
        chk("R5 cmd kept", reqCmd, mCmd);
        hostRead(8'h04, 1'b0, rd); chk("R5 overrun", rd, expStatus(1'b1));
      end
      repeat ($urandom % 4) @(negedge clk);

      // R7 responder fills read buffer
      for (int k = 0; k < 4; k++) begin
        mRbuf[k] = $urandom;
        rbufLoad(2'(k), mRbuf[k]);
      end

      // R3 / R4 completion
      begin
        logic e; logic [7:0] c, t;
        e = 1'($urandom % 2); c = 8'($urandom); t = 8'($urandom);
        complete(e, c, t);
        mErr = e; mCode = c; mInit = t;
      end
      chk("R4 irq on completion", {31'h0, irqPulse}, {31'h0, mIoc});
      hostRead(8'h04, 1'b0, rd); chk("R3 status after done", rd, expStatus(1'b0));
      @(negedge clk);
      chk("R4 irq one cycle", {31'h0, irqPulse}, 32'h0);

      // R7 reads by word and byte
      widx = 2'($urandom % 4);
      hostRead(8'(8'h90 + 4 * widx), 1'b0, rd); chk("R7 word read", rd, mRbuf[widx]);
      begin
        logic [1:0] b;
        b = 2'($urandom % 4);
        hostRead(8'(8'h90 + 4 * widx + b), 1'b1, rd);
        chk("R7 byte read", rd, {24'h0, mRbuf[widx][b*8 +: 8]});
      end
      hostRead(8'(8'hA0 + ($urandom % 16)), 1'b0, rd); chk("R9 outside zero", rd, 32'h0);

      // R8 spurious completion
      if (($urandom % 2) == 0) begin
        complete(~mErr, ~mCode, ~mInit);
        chk("R8 no irq", {31'h0, irqPulse}, 32'h0);
        hostRead(8'h04, 1'b0, rd); chk("R8 status kept", rd, expStatus(1'b0));
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule